// File: doc/BRIEF.md
# Bit-Level I2C Target Transaction Decoder

This block sits on the target side of a two-wire serial bus and turns the raw levels of the clock line (SCL) and the data line (SDA) into byte-level events for a local device. Both lines arrive as asynchronous open-drain levels. They are brought into the system clock domain and turned into edge events. A small line-event machine then follows the protocol, bit by bit.

A START opens a transfer. The first byte that follows is taken as a 7-bit target address plus a direction bit. Each address or write byte is accepted with a low ACK bit, and the device side receives a single-cycle strobe for it. In the read direction, the block asks the device for a byte and shifts it out MSB first. It then samples the controller's acknowledge and reports a NACK to the device side. A STOP closes the transfer. The data level that the block reports is the wired-AND of its own drive and the controller's last level.

Top module: `i2c_target_decoder`

## Requirements
- R1: After synchronous reset, `sda_out` is 1 and no device-side strobe is asserted.
- R2: A falling SDA while SCL is high is a START. It begins capturing a new address byte, and this is also the case inside a transfer (repeated START).
- R3: SDA changes while SCL is low produce no strobe and no protocol action. `sda_out` simply follows the new controller level.
- R4: Bits are sampled on SCL rising edges, MSB first. On the ninth rising edge after a START, `start_stb` pulses with `addr` = byte[7:1] and `rnw` = byte[0].
- R5: In a write transfer (rnw = 0), every later byte raises `wr_stb` on its ninth rising edge, with the byte on `wr_data`.
- R6: On the ninth rising edge of an address or write byte, the block drives SDA low, so `sda_out` reads 0 while SCL stays high.
- R7: In a read transfer, the first rising edge of each byte pulses `rd_req`. `rd_data` is latched one cycle later. `sda_out` then shows the byte MSB first on eight successive rising edges.
- R8: On the ninth rising edge of a read byte, a sampled SDA of 1 pulses `nack_stb` and a 0 pulses nothing. In both cases the next rising edge, including the one that precedes a STOP or repeated START, requests a new byte.
- R9: A rising SDA while SCL is high is a STOP. It pulses `end_stb` only if an address was captured since the last START, and it returns the block to idle.
- R10: Every SCL falling edge releases the block's drive to 1, so after an ACK low `sda_out` returns to the controller's level.
- R11: Every device-side strobe is exactly one system-clock cycle wide.
- R12: When SCL and SDA change in the same cycle, the SCL change is processed first and the SDA change one cycle later. For example, SCL and SDA falling together from idle is not a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Asynchronous bus clock level |
| sda_in | input | 1 | Asynchronous controller data level |
| rd_data | input | 8 | Byte supplied by the device for a read |
| sda_out | output | 1 | Wired-AND data line level |
| start_stb | output | 1 | Transfer start pulse |
| addr | output | 7 | Captured target address |
| rnw | output | 1 | Captured direction, 1 = read |
| wr_stb | output | 1 | Write byte received pulse |
| wr_data | output | 8 | Received write byte |
| rd_req | output | 1 | Read byte request pulse |
| nack_stb | output | 1 | Controller NACK on a read byte |
| end_stb | output | 1 | Transfer end pulse |

## Verification
The main function is exercised with a plain write of several bytes, a write followed by a repeated START into a read, and reads ending in both ACK and NACK. Together these separate address capture from data capture and show that the direction bit steers the machine. Data patterns with alternating and single-set bits show whether the bit order and shift alignment are right. A START/STOP pair with no address tells apart the conditional transfer-end pulse. SDA toggling while SCL is low, and SCL and SDA falling together, show whether the block mistakes data changes for bus conditions.

// File: rtl/i2c_dec_pkg.sv
package i2c_dec_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_RX      = 3'd1,
    PH_ACK_OUT = 3'd2,
    PH_TX      = 3'd3,
    PH_ACK_IN  = 3'd4
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;
      else     chain_q <= {chain_q[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  input  logic hold,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_rise,
  output logic sda_fall
);
  logic last_scl_q, last_sda_q;
  logic scl_chg, sda_chg;

  // One event per cycle: the clock line wins, a data change waits a cycle.
  assign scl_chg = !hold && (scl_s != last_scl_q);
  assign sda_chg = !hold && !scl_chg && (sda_s != last_sda_q);

  assign scl_rise = scl_chg &&  scl_s;
  assign scl_fall = scl_chg && !scl_s;
  assign sda_rise = sda_chg &&  sda_s;
  assign sda_fall = sda_chg && !sda_s;
  assign scl_lvl  = last_scl_q;
  assign sda_lvl  = last_sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_scl_q <= 1'b1;
      last_sda_q <= 1'b1;
    end else begin
      if (scl_chg) last_scl_q <= scl_s;
      if (sda_chg) last_sda_q <= sda_s;
    end
  end

  // R12: a data change seen together with a clock change is deferred.
  a_r12_sda_deferred: assert property (@(posedge clk) disable iff (rst)
    (!hold && scl_s != last_scl_q && sda_s != last_sda_q) |=> (last_sda_q == $past(last_sda_q)));
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_dec_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              hold,
  output logic              drv,
  output logic              start_stb,
  output logic [ADDR_W-1:0] addr,
  output logic              rnw,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic              nack_stb,
  output logic              end_stb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] shift_q;
  logic              addr_seen_q;
  logic              load_q;

  assign hold = load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      bit_q       <= '0;
      shift_q     <= '0;
      addr_seen_q <= 1'b0;
      load_q      <= 1'b0;
      drv         <= 1'b1;
      start_stb   <= 1'b0;
      addr        <= '0;
      rnw         <= 1'b0;
      wr_stb      <= 1'b0;
      wr_data     <= '0;
      rd_req      <= 1'b0;
      nack_stb    <= 1'b0;
      end_stb     <= 1'b0;
    end else begin
      start_stb <= 1'b0;
      wr_stb    <= 1'b0;
      rd_req    <= 1'b0;
      nack_stb  <= 1'b0;
      end_stb   <= 1'b0;
      if (load_q) begin
        // Device byte captured one cycle after the request; MSB goes out now.
        load_q  <= 1'b0;
        drv     <= rd_data[BYTE_W-1];
        shift_q <= {rd_data[BYTE_W-2:0], 1'b0};
      end else if (sda_fall && scl_lvl) begin
        phase_q     <= PH_RX;
        bit_q       <= '0;
        addr_seen_q <= 1'b0;
        drv         <= 1'b1;
      end else if (sda_rise && scl_lvl) begin
        if (addr_seen_q) end_stb <= 1'b1;
        addr_seen_q <= 1'b0;
        phase_q     <= PH_IDLE;
        drv         <= 1'b1;
      end else if (scl_fall) begin
        drv <= 1'b1;
      end else if (scl_rise) begin
        unique case (phase_q)
          PH_IDLE: drv <= 1'b1;
          PH_RX: begin
            drv     <= 1'b1;
            shift_q <= {shift_q[BYTE_W-2:0], sda_lvl};
            if (bit_q == LAST_BIT) begin
              phase_q <= PH_ACK_OUT;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          PH_ACK_OUT: begin
            drv   <= 1'b0;
            bit_q <= '0;
            if (!addr_seen_q) begin
              addr_seen_q <= 1'b1;
              addr        <= shift_q[BYTE_W-1:1];
              rnw         <= shift_q[0];
              start_stb   <= 1'b1;
              phase_q     <= shift_q[0] ? PH_TX : PH_RX;
            end else begin
              wr_data <= shift_q;
              wr_stb  <= 1'b1;
              phase_q <= rnw ? PH_TX : PH_RX;
            end
          end
          PH_TX: begin
            if (bit_q == '0) begin
              rd_req <= 1'b1;
              load_q <= 1'b1;
            end else begin
              drv     <= shift_q[BYTE_W-1];
              shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
            end
            if (bit_q == LAST_BIT) begin
              phase_q <= PH_ACK_IN;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          PH_ACK_IN: begin
            drv     <= 1'b1;
            if (sda_lvl) nack_stb <= 1'b1;
            phase_q <= PH_TX;
            bit_q   <= '0;
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  // R11: strobes last one cycle.
  a_r11_start_pulse: assert property (@(posedge clk) disable iff (rst) start_stb |=> !start_stb);
  a_r11_wr_pulse:    assert property (@(posedge clk) disable iff (rst) wr_stb |=> !wr_stb);
  a_r11_req_pulse:   assert property (@(posedge clk) disable iff (rst) rd_req |=> !rd_req);
  a_r11_nack_pulse:  assert property (@(posedge clk) disable iff (rst) nack_stb |=> !nack_stb);
  a_r11_end_pulse:   assert property (@(posedge clk) disable iff (rst) end_stb |=> !end_stb);
  // R7: the requested byte is taken on the following cycle.
  a_r7_load_follows: assert property (@(posedge clk) disable iff (rst) rd_req |=> !load_q);
  // R9: a transfer end leaves the machine idle with no address held.
  a_r9_end_idle: assert property (@(posedge clk) disable iff (rst)
    end_stb |-> (phase_q == PH_IDLE && !addr_seen_q));
  // R4: a transfer start marks the address as captured.
  a_r4_start_seen: assert property (@(posedge clk) disable iff (rst) start_stb |-> addr_seen_q);
  // R10: a falling clock edge releases the drive.
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && !load_q) |=> drv);
endmodule

// File: rtl/i2c_target_decoder.sv
module i2c_target_decoder #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_out,
  output logic              start_stb,
  output logic [ADDR_W-1:0] addr,
  output logic              rnw,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic              nack_stb,
  output logic              end_stb
);
  logic [1:0] lines_s;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, sda_rise, sda_fall;
  logic hold, drv;

  i2c_line_sync #(.LANES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din ({sda_in, scl_in}), .dout (lines_s)
  );

  i2c_line_events u_events (
    .clk (clk), .rst (rst), .scl_s (lines_s[0]), .sda_s (lines_s[1]), .hold (hold),
    .scl_lvl (scl_lvl), .sda_lvl (sda_lvl), .scl_rise (scl_rise), .scl_fall (scl_fall),
    .sda_rise (sda_rise), .sda_fall (sda_fall)
  );

  i2c_bit_engine #(.BYTE_W(BYTE_W)) u_engine (
    .clk (clk), .rst (rst), .scl_lvl (scl_lvl), .sda_lvl (sda_lvl),
    .scl_rise (scl_rise), .scl_fall (scl_fall), .sda_rise (sda_rise), .sda_fall (sda_fall),
    .rd_data (rd_data), .hold (hold), .drv (drv),
    .start_stb (start_stb), .addr (addr), .rnw (rnw), .wr_stb (wr_stb), .wr_data (wr_data),
    .rd_req (rd_req), .nack_stb (nack_stb), .end_stb (end_stb)
  );

  // Wired-AND of two registered levels.
  assign sda_out = drv & sda_lvl;

  // R1: reset leaves the line released.
  a_r1_released: assert property (@(posedge clk) $past(rst) |-> sda_out);
endmodule

// File: tb/tb_i2c_target_decoder.sv
module tb_i2c_target_decoder;
  localparam int STEP = 8;
  localparam logic [2:0] K_START = 3'd1, K_WR = 3'd2, K_REQ = 3'd3, K_NACK = 3'd4, K_END = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1;
  logic [7:0] rd_data = 8'h00;
  logic sda_out, start_stb, rnw, wr_stb, rd_req, nack_stb, end_stb;
  logic [6:0] addr;
  logic [7:0] wr_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [10:0] exp_q[$];

  always #10 clk = ~clk;

  i2c_target_decoder dut (
    .clk (clk), .rst (rst), .scl_in (scl), .sda_in (sda), .rd_data (rd_data),
    .sda_out (sda_out), .start_stb (start_stb), .addr (addr), .rnw (rnw),
    .wr_stb (wr_stb), .wr_data (wr_data), .rd_req (rd_req), .nack_stb (nack_stb), .end_stb (end_stb)
  );

  function automatic void expect_ev(logic [2:0] k, logic [7:0] d);
    exp_q.push_back({k, d});
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every strobe is compared against the queue head.
  always @(negedge clk) begin
    if (!rst && (start_stb || wr_stb || rd_req || nack_stb || end_stb)) begin
      logic [10:0] got;
      if (start_stb)     got = {K_START, addr, rnw};
      else if (wr_stb)   got = {K_WR, wr_data};
      else if (rd_req)   got = {K_REQ, 8'h00};
      else if (nack_stb) got = {K_NACK, 8'h00};
      else               got = {K_END, 8'h00};
      check("R11 one strobe", 32'($countones({start_stb, wr_stb, rd_req, nack_stb, end_stb})), 1);
      if (exp_q.size() == 0) check("R2-R9 unexpected strobe", 32'(got), 0);
      else check("R4 R5 R7 R8 R9 event", 32'(got), 32'(exp_q.pop_front()));
    end
  end

  task automatic lines(logic c, logic d);
    scl = c; sda = d;
    repeat (STEP) @(posedge clk);
  endtask

  task automatic do_start();
    lines(1, 1); lines(1, 0); lines(0, 0);
  endtask

  task automatic do_stop();
    lines(0, 0); lines(1, 0); lines(1, 1);
  endtask

  task automatic put_bit(logic b);
    lines(0, b); lines(1, b); lines(0, b);
  endtask

  task automatic write_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    lines(0, 1); lines(1, 1);
    @(negedge clk); check("R6 ack low", 32'(sda_out), 0);
    lines(0, 1);
    @(negedge clk); check("R10 released", 32'(sda_out), 1);
  endtask

  task automatic read_byte(logic [7:0] v, logic ack_bit);
    rd_data = v;
    expect_ev(K_REQ, 8'h00);
    for (int i = 7; i >= 0; i--) begin
      lines(0, 1); lines(1, 1);
      @(negedge clk); check("R7 read bit", 32'(sda_out), 32'(v[i]));
    end
    lines(0, ack_bit);
    if (ack_bit) expect_ev(K_NACK, 8'h00);
    lines(1, ack_bit);
    lines(0, ack_bit);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sda_out", 32'(sda_out), 1);
    check("R1 strobes", 32'({start_stb, wr_stb, rd_req, nack_stb, end_stb}), 0);

    // R9: START then STOP with no address gives no end strobe.
    do_start(); do_stop();

    // R4 R5 R6: write to 0x2A, two data bytes, R3 glitches while SCL low.
    expect_ev(K_START, {7'h2A, 1'b0});
    do_start(); write_byte({7'h2A, 1'b0});
    expect_ev(K_WR, 8'hA5); write_byte(8'hA5);
    lines(0, 0); lines(0, 1); lines(0, 0); lines(0, 1);
    @(negedge clk); check("R3 follows controller", 32'(sda_out), 1);
    expect_ev(K_WR, 8'h01); write_byte(8'h01);
    // R2: repeated START into a read of 0x51.
    lines(0, 1);
    expect_ev(K_START, {7'h51, 1'b1});
    do_start(); write_byte({7'h51, 1'b1});
    read_byte(8'h96, 1'b0);
    read_byte(8'h3C, 1'b1);
    // R8: rising edge before STOP is a read bit and requests a byte.
    expect_ev(K_REQ, 8'h00); expect_ev(K_END, 8'h00);
    do_stop();

    // R12: SCL and SDA falling together is not a START.
    lines(0, 0);
    for (int i = 0; i < 9; i++) put_bit(1'b0);
    lines(0, 1); lines(1, 1);

    // Write transfer ended by STOP after one byte.
    expect_ev(K_START, {7'h7F, 1'b0});
    do_start(); write_byte({7'h7F, 1'b0});
    expect_ev(K_WR, 8'h80); write_byte(8'h80);
    expect_ev(K_END, 8'h00);
    do_stop();
    repeat (STEP) @(posedge clk);

    check("R2-R12 queue drained", 32'(exp_q.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule